// File: doc/BRIEF.md
# Counter-Flow Systolic Convolver

This block computes a four-tap convolution on a chain of four multiply-accumulate cells. Each cell keeps one fixed weight. Samples enter at the head of the chain and step one cell toward the tail on each clock. Partial sums start as zero at the tail and step one cell toward the head on each clock. When a partial sum meets a sample inside a cell, the cell adds the product of that sample and its own weight to the sum. A sum that leaves the head cell is a finished result. Each cell is wired only to the cells next to it. No data wire crosses the whole array.

Because the two streams move in opposite directions, a partial sum passes two samples for each cell it crosses. A single stream must therefore place its samples on alternate cycles, with one empty slot between them. A valid flag travels with every sample and with every partial sum. A sum leaves the head marked valid only if a real sample was present at each of the four meetings. Any result that would have needed a missing sample is therefore dropped. If samples are presented on every cycle, the array computes two independent convolutions, one on the even slots and one on the odd slots.

Weights are written one at a time through a small load port. A weight can be written while samples are streaming. The write affects each partial sum from the cycle that sum reaches the rewritten cell.

Top module: `systolic_fir_conv`

## Requirements
- R1: After reset, y_valid_o is 0, y_o is 0, and all four weights are 0. A complete sample window presented before any weight load therefore produces a valid result of 0.
- R2: When wload_i is 1 at a rising edge, wdata_i is written to the weight selected by widx_i. Index 0 selects w1, index 1 selects w2, index 2 selects w3 and index 3 selects w4.
- R3: Let t be a rising edge at which a valid sample was captured, and suppose valid samples were also captured at edges t-6, t-4 and t-2. In the cycle after edge t the block outputs y_o = w1*x(t-6) + w2*x(t-4) + w3*x(t-2) + w4*x(t), with y_valid_o = 1.
- R4: In the cycle after edge t, y_valid_o is 1 exactly when valid samples were captured at all four edges t-6, t-4, t-2 and t.
- R5: Whenever y_valid_o is 0, y_o is 0.
- R6: Samples and weights are signed 8-bit two's complement. y_o is signed 18-bit two's complement and never overflows. All weights and samples at -128 give +65536. Weights at +127 with samples at -128 give -65024.
- R7: With a valid sample on every cycle, every output cycle carries a valid result. Each result follows R3, so the even slots and the odd slots form two separate convolutions.
- R8: A weight keeps its value while wload_i is 0. Writing one index leaves the other three weights unchanged.
- R9: A weight written while results are in flight is picked up per term. For the result shown after edge t, the w1 term uses the w1 value held just before edge t-3. The w2 term uses the value held just before edge t-2, the w3 term the value before t-1, and the w4 term the value before t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 8 | Signed input sample |
| sample_valid_i | input | 1 | sample_i holds a sample in this slot |
| wload_i | input | 1 | Write a weight at this edge |
| widx_i | input | 2 | Weight select, 0 = w1 through 3 = w4 |
| wdata_i | input | 8 | Signed weight value |
| y_o | output | 18 | Signed result, 0 when not valid |
| y_valid_o | output | 1 | y_o holds a finished result |

## Verification
The two functions that can fall in the same cycle are a weight write and the accumulation of a result that is still in flight. A rewritten cell may already have been passed by some sums and not yet reached by others. The bench provokes this in its final phase: it issues weight writes at random times, to random indices, in the middle of a spaced random sample stream. The bench's model records the weight set in force before every edge, so each term of the expected sum can use the snapshot R9 assigns to it. A mismatch in any single term is reported against R9.

// File: rtl/sys_conv_pkg.sv
package sys_conv_pkg;
  parameter int DATA_W = 8;
  parameter int TAPS   = 4;
  localparam int IDX_W = $clog2(TAPS);
  localparam int ACC_W = 2 * DATA_W + $clog2(TAPS);
endpackage

// File: rtl/conv_weight_bank.sv
module conv_weight_bank #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 4,
  parameter int IDX_W  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [TAPS-1:0][DATA_W-1:0]  w_o
);
  logic [TAPS-1:0][DATA_W-1:0] w_q;

  for (genvar k = 0; k < TAPS; k++) begin : g_w
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          w_q[k] <= '0;
      else if (load_i && (idx_i == IDX_W'(k))) w_q[k] <= data_i;
    end
  end

  assign w_o = w_q;
endmodule

// File: rtl/conv_sample_line.sv
// Forward sample path: cell 0 sees the live input, cell k sees it k cycles later.
module conv_sample_line #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DATA_W-1:0]            sample_i,
  input  logic                         valid_i,
  output logic [TAPS-1:0][DATA_W-1:0]  cell_x_o,
  output logic [TAPS-1:0]              cell_v_o
);
  localparam int STAGES = TAPS - 1;

  logic [STAGES-1:0][DATA_W-1:0] x_q;
  logic [STAGES-1:0]             v_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        x_q[s] <= '0;
        v_q[s] <= 1'b0;
      end else if (s == 0) begin
        x_q[s] <= sample_i;
        v_q[s] <= valid_i;
      end else begin
        x_q[s] <= x_q[(s == 0) ? 0 : s-1];
        v_q[s] <= v_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign cell_x_o[0] = sample_i;
  assign cell_v_o[0] = valid_i;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign cell_x_o[k] = x_q[k-1];
    assign cell_v_o[k] = v_q[k-1];
  end
endmodule

// File: rtl/conv_mac_cell.sv
module conv_mac_cell #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] w_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic                     x_valid_i,
  input  logic signed [ACC_W-1:0]  psum_i,
  input  logic                     psum_valid_i,
  output logic signed [ACC_W-1:0]  psum_o,
  output logic                     psum_valid_o
);
  logic signed [2*DATA_W-1:0] prod;
  logic signed [ACC_W-1:0]    prod_ext;
  logic signed [ACC_W-1:0]    sum_d;

  assign prod     = w_i * x_i;
  assign prod_ext = ACC_W'(prod);
  assign sum_d    = psum_i + prod_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psum_o       <= '0;
      psum_valid_o <= 1'b0;
    end else begin
      psum_o       <= sum_d;
      psum_valid_o <= psum_valid_i & x_valid_i;
    end
  end
endmodule

// File: rtl/systolic_fir_conv.sv
module systolic_fir_conv
  import sys_conv_pkg::*;
#(
  parameter int DATA_W = sys_conv_pkg::DATA_W,
  parameter int TAPS   = sys_conv_pkg::TAPS,
  localparam int IDX_W = $clog2(TAPS),
  localparam int ACC_W = 2 * DATA_W + $clog2(TAPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic                     sample_valid_i,
  input  logic                     wload_i,
  input  logic [IDX_W-1:0]         widx_i,
  input  logic signed [DATA_W-1:0] wdata_i,
  output logic signed [ACC_W-1:0]  y_o,
  output logic                     y_valid_o
);
  logic [TAPS-1:0][DATA_W-1:0] w_bank;
  logic [TAPS-1:0][DATA_W-1:0] cell_x;
  logic [TAPS-1:0]             cell_v;
  logic signed [ACC_W-1:0]     psum [TAPS];
  logic [TAPS-1:0]             psum_v;

  conv_weight_bank #(.DATA_W(DATA_W), .TAPS(TAPS), .IDX_W(IDX_W)) i_wbank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wload_i),
    .idx_i  (widx_i),
    .data_i (wdata_i),
    .w_o    (w_bank)
  );

  conv_sample_line #(.DATA_W(DATA_W), .TAPS(TAPS)) i_xline (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .valid_i  (sample_valid_i),
    .cell_x_o (cell_x),
    .cell_v_o (cell_v)
  );

  // Cell k holds the weight of tap TAPS-k; sums enter as zero at the tail cell.
  for (genvar k = 0; k < TAPS; k++) begin : g_cell
    logic signed [ACC_W-1:0] ps_in;
    logic                    pv_in;
    if (k == TAPS - 1) begin : g_tail
      assign ps_in = '0;
      assign pv_in = 1'b1;
    end else begin : g_mid
      assign ps_in = psum[k+1];
      assign pv_in = psum_v[k+1];
    end

    conv_mac_cell #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .w_i          (w_bank[TAPS-1-k]),
      .x_i          (cell_x[k]),
      .x_valid_i    (cell_v[k]),
      .psum_i       (ps_in),
      .psum_valid_i (pv_in),
      .psum_o       (psum[k]),
      .psum_valid_o (psum_v[k])
    );
  end

  assign y_valid_o = psum_v[0];
  assign y_o       = psum_v[0] ? psum[0] : '0;
endmodule

// File: rtl/conv_checker.sv
module conv_checker #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 4,
  parameter int IDX_W  = 2,
  parameter int ACC_W  = 18
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic signed [DATA_W-1:0] sample_i,
  input logic                     sample_valid_i,
  input logic                     wload_i,
  input logic [IDX_W-1:0]         widx_i,
  input logic signed [DATA_W-1:0] wdata_i,
  input logic signed [ACC_W-1:0]  y_o,
  input logic                     y_valid_o
);
  localparam int LIM = TAPS * (1 << (2 * DATA_W - 2));

  logic [3:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age <= '0;
    else if (age != 4'd15)    age <= age + 4'd1;
  end

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_valid_o |-> (y_o == '0)); // R5

  AST_VALID_NEEDS_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> ($past(sample_valid_i, 1) && $past(sample_valid_i, 3) &&
                   $past(sample_valid_i, 5) && $past(sample_valid_i, 7))); // R4

  AST_WINDOW_GIVES_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age >= 4'd8) && $past(sample_valid_i, 1) && $past(sample_valid_i, 3) &&
     $past(sample_valid_i, 5) && $past(sample_valid_i, 7)) |-> y_valid_o); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(y_o) <= LIM) && (int'(y_o) >= -LIM)); // R6
endmodule

bind systolic_fir_conv conv_checker #(
  .DATA_W(DATA_W), .TAPS(TAPS), .IDX_W(IDX_W), .ACC_W(ACC_W)
) i_conv_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_i       (sample_i),
  .sample_valid_i (sample_valid_i),
  .wload_i        (wload_i),
  .widx_i         (widx_i),
  .wdata_i        (wdata_i),
  .y_o            (y_o),
  .y_valid_o      (y_valid_o)
);

// File: tb/test_systolic_fir_conv.sv
`timescale 1ns/1ps
module test_systolic_fir_conv;
  localparam time CLK_P = 20ns;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic signed [7:0] sample_i = '0;
  logic              sample_valid_i = 1'b0;
  logic              wload_i = 1'b0;
  logic [1:0]        widx_i = '0;
  logic signed [7:0] wdata_i = '0;
  logic signed [17:0] y_o;
  logic              y_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_tag = "R3";

  // model state: per-edge snapshots (edge index mod 8)
  int  wm [4];
  bit  hv [8];
  int  hx [8];
  int  hw [8][4];
  int  edge_n = 0;

  systolic_fir_conv i_systolic_fir_conv (
    .clk_i, .rst_ni, .sample_i, .sample_valid_i, .wload_i,
    .widx_i, .wdata_i, .y_o, .y_valid_o
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int slot(input int e);
    return ((e % 8) + 8) % 8;
  endfunction

  always @(posedge clk_i) begin
    if (rst_ni) begin
      hv[slot(edge_n)] = sample_valid_i;
      hx[slot(edge_n)] = int'(sample_i);
      for (int k = 0; k < 4; k++) hw[slot(edge_n)][k] = wm[k];
      if (wload_i) wm[widx_i] = int'(wdata_i);
      edge_n++;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && edge_n > 0) begin
      int t;
      bit ev;
      int ey;
      t  = edge_n - 1;
      ev = (t >= 6) && hv[slot(t-6)] && hv[slot(t-4)] && hv[slot(t-2)] && hv[slot(t)];
      ey = 0;
      if (ev)
        ey = hw[slot(t-3)][0] * hx[slot(t-6)] + hw[slot(t-2)][1] * hx[slot(t-4)]
           + hw[slot(t-1)][2] * hx[slot(t-2)] + hw[slot(t)][3]   * hx[slot(t)];
      chk("R4", y_valid_o == ev, int'(y_valid_o), int'(ev));
      if (ev) chk(cur_tag, int'(y_o) == ey, int'(y_o), ey);
      else    chk("R5", y_o == '0, int'(y_o), 0);
    end
  end

  task automatic step(input bit v, input int x, input bit wl = 0,
                      input int idx = 0, input int wd = 0);
    @(negedge clk_i); #1;
    sample_valid_i = v;
    sample_i       = 8'(x);
    wload_i        = wl;
    widx_i         = 2'(idx);
    wdata_i        = 8'(wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic load4(input int a, input int b, input int c, input int d);
    step(0, 0, 1, 0, a); step(0, 0, 1, 1, b);
    step(0, 0, 1, 2, c); step(0, 0, 1, 3, d);
    idle(1);
  endtask

  task automatic spaced(input int x);
    step(1, x); step(0, 0);
  endtask

  function automatic int rnd8();
    return int'($urandom_range(255)) - 128;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      hv[i] = 0; hx[i] = 0;
      for (int k = 0; k < 4; k++) hw[i][k] = 0;
    end
    for (int k = 0; k < 4; k++) wm[k] = 0;

    #(CLK_P * 3);
    chk("R1", y_valid_o == 1'b0, int'(y_valid_o), 0);
    chk("R1", y_o == '0, int'(y_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R1", y_valid_o == 1'b0, int'(y_valid_o), 0);

    // R1: reset weights are zero
    cur_tag = "R1";
    spaced(11); spaced(-22); spaced(33); spaced(-44);
    idle(8);

    // R2: impulse reads back each weight in tap order
    cur_tag = "R2";
    load4(3, -5, 7, 2);
    spaced(1); spaced(0); spaced(0); spaced(0); spaced(0); spaced(0); spaced(0);
    idle(8);

    // R3: spaced random stream
    cur_tag = "R3";
    load4(rnd8(), rnd8(), rnd8(), rnd8());
    for (int i = 0; i < 40; i++) spaced(rnd8());
    idle(8);

    // R4: random gaps break windows
    cur_tag = "R4";
    for (int i = 0; i < 60; i++) begin
      step(($urandom_range(4) != 0), rnd8());
      if ($urandom_range(2) != 0) step(0, 0);
    end
    idle(8);

    // R7: full-rate stream, two interleaved convolutions
    cur_tag = "R7";
    for (int i = 0; i < 30; i++) step(1, rnd8());
    idle(8);

    // R6: extremes
    cur_tag = "R6";
    load4(-128, -128, -128, -128);
    for (int i = 0; i < 4; i++) spaced(-128);
    idle(8);
    load4(127, 127, 127, 127);
    for (int i = 0; i < 4; i++) spaced(-128);
    idle(8);

    // R8: single-index write leaves others untouched
    cur_tag = "R8";
    load4(9, -9, 4, -4);
    step(0, 0, 1, 2, -60); idle(1);
    idle(3);
    for (int i = 0; i < 12; i++) spaced(rnd8());
    idle(8);

    // R9: weight writes land while results are in flight
    cur_tag = "R9";
    for (int i = 0; i < 120; i++) begin
      bit wl;
      wl = ($urandom_range(5) == 0);
      step((i % 2) == 0, rnd8(), wl, int'($urandom_range(3)), rnd8());
    end
    idle(10);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule